// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block sits between a set of free-running source clocks and the clock pins of a clock generator. It lets each output through, holds it in a quiet level, or shuts it off. The decision comes from two active-low stop requests, one for the peripheral group and one for the processor group, and from a software run bit that can request the peripheral stop as well. Each output also has a stop-control bit that makes it either stoppable or free-running, and an enable bit that forces it off.

Single-ended outputs are gated to low. A stopped differential pair parks with its true line high and its complement line low. A disabled pair drives both lines low. All stop and enable requests are asynchronous to the output clocks. Each lane brings its requests into its own source-clock domain through a two-stage synchronizer. It changes state only on the falling edge of its source, while that source is low. As a result, no output ever produces a shortened pulse when it stops or restarts. The parameter `DIF_CPU_GRP` assigns each differential pair to the processor group or to the peripheral group. All single-ended outputs belong to the peripheral group.

Top module: `clkstop_gate`

## Requirements
- R1: While `rst_n` is low, every single-ended output, every true line and every complement line is low.
- R2: With its enable bit at 1 and no stop request applying to it, every output follows its source clock. For a pair, the complement line is the inverse of the true line.
- R3: While `pci_stop_n` is 0, each stoppable single-ended output stays low. Each stoppable pair whose `DIF_CPU_GRP` bit is 0 holds true=1 and complement=0.
- R4: An output whose stop-control bit is 0 keeps running while any stop request is active.
- R5: After a peripheral stop is released, a stopped single-ended output gives its first rising edge within 3 source periods. A parked pair's true line gives its first falling edge within 4 source periods.
- R6: `sw_run` at 0 stops the same outputs as `pci_stop_n` at 0. Returning `sw_run` to 1 (with the pin at 1) lets them run again.
- R7: `cpu_stop_n` at 0 parks only the stoppable pairs whose `DIF_CPU_GRP` bit is 1. The peripheral stop has no effect on those pairs, and the processor stop has no effect on any other output.
- R8: An output whose enable bit is 0 is low: a single-ended output is low, and a pair drives both lines low. This holds even while a stop request would park the pair.
- R9: No output ever gives a high pulse shorter than the high phase of its source clock, and the two lines of a pair are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all lanes |
| se_src_clk | input | NSE | Source clock of each single-ended lane |
| dif_src_clk | input | NDIF | Source clock of each differential lane |
| pci_stop_n | input | 1 | Active-low stop request for the peripheral group |
| cpu_stop_n | input | 1 | Active-low stop request for the processor group |
| sw_run | input | 1 | Software run bit; 0 requests the peripheral stop |
| se_stoppable | input | NSE | 1 = single-ended lane obeys the stop, 0 = free-running |
| dif_stoppable | input | NDIF | 1 = pair obeys its group's stop, 0 = free-running |
| se_oe | input | NSE | Enable per single-ended lane; 0 forces low |
| dif_oe | input | NDIF | Enable per pair; 0 forces both lines low |
| se_clk | output | NSE | Gated single-ended clocks |
| dif_t | output | NDIF | Gated true line of each pair |
| dif_c | output | NDIF | Gated complement line of each pair |

## Verification
The bench times the restart after a peripheral stop is released. A design whose synchronizer is too deep, or whose gate waits a whole extra cycle, misses the three- and four-period bounds. It drives the processor and peripheral stops separately and watches pairs of both groups. A design that wires a pair to the wrong stop parks an output that should run, or lets one run that should park. A disabled pair is checked while the processor stop is active, which exposes a priority mix-up that would leave the true line parked high. A monitor measures every high pulse on every output. Gating on the rising edge, or switching while the source is high, shows up as a pulse shorter than the source's high phase.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  // Lane state held in each output's own clock domain.
  typedef enum logic [1:0] {
    LANE_OFF  = 2'b00,
    LANE_RUN  = 2'b01,
    LANE_PARK = 2'b10
  } lane_mode_e;

  // Does a stop request apply to this lane?
  function automatic logic lane_halt(input logic stoppable, input logic use_cpu,
                                     input logic pci_halt, input logic cpu_halt);
    return stoppable & (use_cpu ? cpu_halt : pci_halt);
  endfunction

  // Disable wins over stop; stop parks a pair and silences a single-ended lane.
  function automatic lane_mode_e pick_mode(input logic enabled, input logic halt,
                                           input logic can_park);
    if (!enabled) return LANE_OFF;
    if (halt)     return can_park ? LANE_PARK : LANE_OFF;
    return LANE_RUN;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/clkstop_core.sv
`timescale 1ns/1ps
module clkstop_core
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit CAN_PARK    = 1'b0
) (
  input  logic       src_clk,
  input  logic       rst_n,
  input  logic       en_req,
  input  logic       halt_req,
  output lane_mode_e mode_q
);

  logic [1:0] req_s;

  clkstop_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk   (src_clk),
    .rst_n (rst_n),
    .d     ({en_req, halt_req}),
    .q     (req_s)
  );

  // Mode moves only at the falling edge, i.e. while the source is low.
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LANE_OFF;
    else        mode_q <= pick_mode(req_s[1], req_s[0], CAN_PARK);
  end

endmodule

// File: rtl/clkstop_se_lane.sv
`timescale 1ns/1ps
module clkstop_se_lane
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic halt_req,
  output logic clk_out
);

  lane_mode_e mode_q;

  clkstop_core #(.SYNC_STAGES(SYNC_STAGES), .CAN_PARK(1'b0)) u_core (
    .src_clk  (src_clk),
    .rst_n    (rst_n),
    .en_req   (en_req),
    .halt_req (halt_req),
    .mode_q   (mode_q)
  );

  assign clk_out = src_clk & (mode_q == LANE_RUN);

endmodule

// File: rtl/clkstop_dif_lane.sv
`timescale 1ns/1ps
module clkstop_dif_lane
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic halt_req,
  output logic out_t,
  output logic out_c
);

  lane_mode_e mode_q;
  logic       run_w;
  logic       park_hi_q;  // park level for the true line, moved while source is high
  logic       crun_q;     // complement enable, moved while source is high

  clkstop_core #(.SYNC_STAGES(SYNC_STAGES), .CAN_PARK(1'b1)) u_core (
    .src_clk  (src_clk),
    .rst_n    (rst_n),
    .en_req   (en_req),
    .halt_req (halt_req),
    .mode_q   (mode_q)
  );

  assign run_w = (mode_q == LANE_RUN);

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      park_hi_q <= 1'b0;
      crun_q    <= 1'b0;
    end else begin
      park_hi_q <= (mode_q == LANE_PARK);
      crun_q    <= run_w;
    end
  end

  assign out_t = park_hi_q | (src_clk & run_w);
  assign out_c = ~src_clk & crun_q;

endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int              NSE         = 3,
  parameter int              NDIF        = 4,
  parameter logic [NDIF-1:0] DIF_CPU_GRP = 4'b1100,
  parameter int              SYNC_STAGES = 2
) (
  input  logic            rst_n,
  input  logic [NSE-1:0]  se_src_clk,
  input  logic [NDIF-1:0] dif_src_clk,
  input  logic            pci_stop_n,
  input  logic            cpu_stop_n,
  input  logic            sw_run,
  input  logic [NSE-1:0]  se_stoppable,
  input  logic [NDIF-1:0] dif_stoppable,
  input  logic [NSE-1:0]  se_oe,
  input  logic [NDIF-1:0] dif_oe,
  output logic [NSE-1:0]  se_clk,
  output logic [NDIF-1:0] dif_t,
  output logic [NDIF-1:0] dif_c
);

  logic pci_halt;
  logic cpu_halt;

  assign pci_halt = ~pci_stop_n | ~sw_run;
  assign cpu_halt = ~cpu_stop_n;

  for (genvar i = 0; i < NSE; i++) begin : g_se
    clkstop_se_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
      .src_clk  (se_src_clk[i]),
      .rst_n    (rst_n),
      .en_req   (se_oe[i]),
      .halt_req (lane_halt(se_stoppable[i], 1'b0, pci_halt, cpu_halt)),
      .clk_out  (se_clk[i])
    );
  end

  for (genvar i = 0; i < NDIF; i++) begin : g_dif
    clkstop_dif_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
      .src_clk  (dif_src_clk[i]),
      .rst_n    (rst_n),
      .en_req   (dif_oe[i]),
      .halt_req (lane_halt(dif_stoppable[i], DIF_CPU_GRP[i], pci_halt, cpu_halt)),
      .out_t    (dif_t[i]),
      .out_c    (dif_c[i])
    );
  end

endmodule

// File: rtl/clkstop_gate_chk.sv
`timescale 1ns/1ps
module clkstop_gate_chk #(
  parameter int              NSE         = 3,
  parameter int              NDIF        = 4,
  parameter logic [NDIF-1:0] DIF_CPU_GRP = 4'b1100
) (
  input logic            rst_n,
  input logic [NSE-1:0]  se_src_clk,
  input logic [NDIF-1:0] dif_src_clk,
  input logic            pci_stop_n,
  input logic            cpu_stop_n,
  input logic            sw_run,
  input logic [NSE-1:0]  se_stoppable,
  input logic [NDIF-1:0] dif_stoppable,
  input logic [NSE-1:0]  se_oe,
  input logic [NDIF-1:0] dif_oe,
  input logic [NSE-1:0]  se_clk,
  input logic [NDIF-1:0] dif_t,
  input logic [NDIF-1:0] dif_c
);

  logic pci_req;
  logic cpu_req;
  assign pci_req = !pci_stop_n || !sw_run;
  assign cpu_req = !cpu_stop_n;

  // Single-ended lanes: sampled at the falling edge, i.e. during the high phase.
  for (genvar i = 0; i < NSE; i++) begin : g_se_chk
    logic off_w, free_w, halt_w;
    assign off_w  = !se_oe[i];
    assign free_w = se_oe[i] && !se_stoppable[i];
    assign halt_w = se_oe[i] && se_stoppable[i] && pci_req;

    // R8
    a_r8_se_disabled_low: assert property (@(negedge se_src_clk[i]) disable iff (!rst_n)
      (off_w && $past(off_w) && $past(off_w, 2) && $past(off_w, 3)
       && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)) |-> !se_clk[i])
      else $error("a_r8_se_disabled_low lane %0d", i);

    // R4
    a_r4_se_free_runs: assert property (@(negedge se_src_clk[i]) disable iff (!rst_n)
      (free_w && $past(free_w) && $past(free_w, 2) && $past(free_w, 3)
       && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)) |-> se_clk[i])
      else $error("a_r4_se_free_runs lane %0d", i);

    // R3 / R6
    a_r3_se_stopped_low: assert property (@(negedge se_src_clk[i]) disable iff (!rst_n)
      (halt_w && $past(halt_w) && $past(halt_w, 2) && $past(halt_w, 3)
       && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)) |-> !se_clk[i])
      else $error("a_r3_se_stopped_low lane %0d", i);
  end

  // Pairs: sampled at the rising edge, i.e. during the source low phase.
  for (genvar i = 0; i < NDIF; i++) begin : g_dif_chk
    logic off_w, free_w, halt_w;
    assign off_w  = !dif_oe[i];
    assign free_w = dif_oe[i] && !dif_stoppable[i];
    assign halt_w = dif_oe[i] && dif_stoppable[i] && (DIF_CPU_GRP[i] ? cpu_req : pci_req);

    // R3 and R7: parked pair shows true high, complement low
    a_r3_dif_parked: assert property (@(posedge dif_src_clk[i]) disable iff (!rst_n)
      (halt_w && $past(halt_w) && $past(halt_w, 2) && $past(halt_w, 3)
       && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)) |-> (dif_t[i] && !dif_c[i]))
      else $error("a_r3_dif_parked lane %0d", i);

    // R8
    a_r8_dif_disabled_low: assert property (@(posedge dif_src_clk[i]) disable iff (!rst_n)
      (off_w && $past(off_w) && $past(off_w, 2) && $past(off_w, 3)
       && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)) |-> (!dif_t[i] && !dif_c[i]))
      else $error("a_r8_dif_disabled_low lane %0d", i);

    // R4: running pair in its low phase has true low, complement high
    a_r4_dif_free_runs: assert property (@(posedge dif_src_clk[i]) disable iff (!rst_n)
      (free_w && $past(free_w) && $past(free_w, 2) && $past(free_w, 3)
       && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)) |-> (!dif_t[i] && dif_c[i]))
      else $error("a_r4_dif_free_runs lane %0d", i);

    // R9
    a_r9_dif_no_overlap: assert property (@(posedge dif_src_clk[i]) disable iff (!rst_n)
      !(dif_t[i] && dif_c[i]))
      else $error("a_r9_dif_no_overlap lane %0d", i);
  end

endmodule

bind clkstop_gate clkstop_gate_chk #(
  .NSE(NSE), .NDIF(NDIF), .DIF_CPU_GRP(DIF_CPU_GRP)
) u_chk (
  .rst_n(rst_n), .se_src_clk(se_src_clk), .dif_src_clk(dif_src_clk),
  .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n), .sw_run(sw_run),
  .se_stoppable(se_stoppable), .dif_stoppable(dif_stoppable),
  .se_oe(se_oe), .dif_oe(dif_oe), .se_clk(se_clk), .dif_t(dif_t), .dif_c(dif_c)
);

// File: tb/clkstop_gate_tb.sv
`timescale 1ns/1ps
module clkstop_gate_tb;

  localparam int NSE  = 3;
  localparam int NDIF = 4;
  localparam logic [NDIF-1:0] CPU_GRP = 4'b1100;   // pairs 2,3 in processor group
  localparam real SE_HALF  = 12.0;
  localparam real DIF_HALF = 4.0;
  localparam int  ST_RUN = 0, ST_LOW = 1, ST_PARK = 2;

  logic clk = 1'b0;    // 125 MHz, feeds every pair
  logic pclk = 1'b0;   // slower source for single-ended lanes
  always #4  clk  = ~clk;
  always #12 pclk = ~pclk;

  logic            rst_n;
  logic            pci_stop_n, cpu_stop_n, sw_run;
  logic [NSE-1:0]  se_stoppable, se_oe, se_clk;
  logic [NDIF-1:0] dif_stoppable, dif_oe, dif_t, dif_c;

  clkstop_gate #(.NSE(NSE), .NDIF(NDIF), .DIF_CPU_GRP(CPU_GRP)) u_dut (
    .rst_n(rst_n), .se_src_clk({NSE{pclk}}), .dif_src_clk({NDIF{clk}}),
    .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n), .sw_run(sw_run),
    .se_stoppable(se_stoppable), .dif_stoppable(dif_stoppable),
    .se_oe(se_oe), .dif_oe(dif_oe), .se_clk(se_clk), .dif_t(dif_t), .dif_c(dif_c)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int runts    = 0;
  int pulses   = 0;
  bit done     = 1'b0;

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // ---------------- scoreboard ----------------
  typedef struct { int kind; int idx; int st; string tag; } exp_t;
  exp_t exp_q[$];
  bit   mon_busy = 1'b0;
  event push_ev, idle_ev;

  task automatic expect_lane(input int kind, input int idx, input int st, input string tag);
    exp_t e;
    e.kind = kind; e.idx = idx; e.st = st; e.tag = tag;
    exp_q.push_back(e);
    -> push_ev;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || mon_busy) @(idle_ev);
  endtask

  function automatic logic samp_t(input exp_t e);
    return (e.kind == 0) ? se_clk[e.idx] : dif_t[e.idx];
  endfunction
  function automatic logic samp_c(input exp_t e);
    return (e.kind == 0) ? 1'b0 : dif_c[e.idx];
  endfunction

  initial begin : monitor
    exp_t cur;
    int   n_hi, n_chi, n_tog, n_bad;
    logic tv, cv, prev;
    bit   ok;
    string exp_s;
    forever begin
      while (exp_q.size() == 0) @(push_ev);
      cur = exp_q.pop_front();
      mon_busy = 1'b1;
      n_hi = 0; n_chi = 0; n_tog = 0; n_bad = 0;
      #0.5;
      prev = samp_t(cur);
      for (int k = 0; k < 120; k++) begin
        tv = samp_t(cur);
        cv = samp_c(cur);
        if (tv) n_hi++;
        if (cv) n_chi++;
        if (tv != prev) n_tog++;
        prev = tv;
        if (cur.kind == 1 && cur.st == ST_RUN && cv == tv) n_bad++;
        if (k < 119) #1;
      end
      #0.5;
      case (cur.st)
        ST_RUN:  begin ok = (n_tog >= 4) && (n_bad == 0); exp_s = "toggling, complement inverse"; end
        ST_LOW:  begin ok = (n_hi == 0) && (n_chi == 0);  exp_s = "true 0, complement 0"; end
        default: begin ok = (n_hi == 120) && (n_chi == 0); exp_s = "true 1, complement 0"; end
      endcase
      check(ok, $sformatf("%s %s%0d", cur.tag, (cur.kind == 0) ? "se" : "dif", cur.idx),
            $sformatf("hi=%0d c_hi=%0d edges=%0d pair_err=%0d", n_hi, n_chi, n_tog, n_bad), exp_s);
      mon_busy = 1'b0;
      -> idle_ev;
    end
  end

  // ---------------- short-pulse monitor (R9) ----------------
  for (genvar g = 0; g < NSE; g++) begin : g_se_mon
    realtime rise_at = -1.0;
    always @(posedge se_clk[g]) rise_at = $realtime;
    always @(negedge se_clk[g]) if (rst_n && rise_at >= 0.0) begin
      pulses++;
      if ($realtime - rise_at < SE_HALF - 0.01) begin
        runts++;
        $display("runt on se%0d: %0.2f ns", g, $realtime - rise_at);
      end
    end
  end
  for (genvar g = 0; g < NDIF; g++) begin : g_dif_mon
    realtime rise_t = -1.0;
    realtime rise_c = -1.0;
    always @(posedge dif_t[g]) rise_t = $realtime;
    always @(posedge dif_c[g]) rise_c = $realtime;
    always @(negedge dif_t[g]) if (rst_n && rise_t >= 0.0) begin
      pulses++;
      if ($realtime - rise_t < DIF_HALF - 0.01) begin
        runts++;
        $display("runt on dif%0d true: %0.2f ns", g, $realtime - rise_t);
      end
    end
    always @(negedge dif_c[g]) if (rst_n && rise_c >= 0.0) begin
      pulses++;
      if ($realtime - rise_c < DIF_HALF - 0.01) begin
        runts++;
        $display("runt on dif%0d complement: %0.2f ns", g, $realtime - rise_c);
      end
    end
  end

  // ---------------- driver ----------------
  initial begin : driver
    realtime t0;
    rst_n = 1'b0; pci_stop_n = 1'b1; cpu_stop_n = 1'b1; sw_run = 1'b1;
    se_oe = '1; dif_oe = '1;
    se_stoppable  = 3'b011;   // se2 free-running
    dif_stoppable = 4'b0111;  // dif3 free-running
    #53;
    check(se_clk == '0 && dif_t == '0 && dif_c == '0, "R1 reset",
          $sformatf("se=%b t=%b c=%b", se_clk, dif_t, dif_c), "all zero");
    #2 rst_n = 1'b1;
    #100;

    // R2: all running
    for (int i = 0; i < NSE; i++)  expect_lane(0, i, ST_RUN, "R2");
    for (int i = 0; i < NDIF; i++) expect_lane(1, i, ST_RUN, "R2");
    drain();

    // R3 / R4 / R7: peripheral stop pin
    pci_stop_n = 1'b0; #100;
    expect_lane(0, 0, ST_LOW,  "R3");
    expect_lane(0, 1, ST_LOW,  "R3");
    expect_lane(0, 2, ST_RUN,  "R4");
    expect_lane(1, 0, ST_PARK, "R3");
    expect_lane(1, 1, ST_PARK, "R3");
    expect_lane(1, 2, ST_RUN,  "R7");
    expect_lane(1, 3, ST_RUN,  "R4");
    drain();

    // R5: restart latency, single-ended
    t0 = $realtime; pci_stop_n = 1'b1;
    @(posedge se_clk[0]);
    check($realtime - t0 <= 3.0 * 2.0 * SE_HALF, "R5 se0 restart",
          $sformatf("%0.1f ns", $realtime - t0), "<= 72 ns");
    #3;
    pci_stop_n = 1'b0; #100;
    t0 = $realtime; pci_stop_n = 1'b1;
    @(negedge dif_t[0]);
    check($realtime - t0 <= 4.0 * 2.0 * DIF_HALF, "R5 dif0 restart",
          $sformatf("%0.1f ns", $realtime - t0), "<= 32 ns");
    #3;
    #100;
    expect_lane(0, 0, ST_RUN, "R5");
    expect_lane(1, 0, ST_RUN, "R5");
    drain();

    // R6: software stop bit
    sw_run = 1'b0; #100;
    expect_lane(0, 0, ST_LOW,  "R6");
    expect_lane(0, 2, ST_RUN,  "R6");
    expect_lane(1, 1, ST_PARK, "R6");
    expect_lane(1, 2, ST_RUN,  "R6");
    drain();
    sw_run = 1'b1; #100;
    expect_lane(0, 0, ST_RUN, "R6");
    expect_lane(1, 1, ST_RUN, "R6");
    drain();

    // R7: processor stop
    cpu_stop_n = 1'b0; #100;
    expect_lane(1, 2, ST_PARK, "R7");
    expect_lane(1, 3, ST_RUN,  "R7");
    expect_lane(1, 0, ST_RUN,  "R7");
    expect_lane(0, 1, ST_RUN,  "R7");
    drain();

    // R8: enables, including a pair that the processor stop would park
    se_oe[1] = 1'b0; dif_oe[0] = 1'b0; dif_oe[2] = 1'b0; dif_oe[3] = 1'b0; #100;
    expect_lane(0, 1, ST_LOW, "R8");
    expect_lane(1, 0, ST_LOW, "R8");
    expect_lane(1, 2, ST_LOW, "R8");
    expect_lane(1, 3, ST_LOW, "R8");
    expect_lane(0, 0, ST_RUN, "R8");
    drain();
    se_oe = '1; dif_oe = '1; #100;
    expect_lane(1, 2, ST_PARK, "R8");
    expect_lane(1, 3, ST_RUN,  "R8");
    expect_lane(0, 1, ST_RUN,  "R8");
    drain();
    cpu_stop_n = 1'b1; #100;
    expect_lane(1, 2, ST_RUN, "R7");
    drain();

    // R9: no shortened high pulse anywhere
    check(runts == 0 && pulses > 100, "R9 pulse widths",
          $sformatf("runts=%0d pulses=%0d", runts, pulses), "runts=0 pulses>100");

    finish_run();
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule